// File: doc/BRIEF.md
# Tagged Queue Mailbox Cell

This block is a single hardware mailbox cell. Several requesters share it to pass data words in order. Each request arrives already decoded: a valid strobe, a direction, a two-bit view code and a requester ID. The cell holds a small power-of-two queue of data words and a tag word. The tag word carries an empty flag, a full flag, a spare software flag, the entry count and the log2 depth code. The views expose the same storage in different ways:

- A raw view peeks at or patches data without moving the queue.
- A tag view reads and rewrites the flags.
- Two queue views push and pop entries. One of them waits; the other never waits.

A waiting queue access that meets the empty flag (on a read) or the full flag (on a write) is not performed. The cell answers it with a retry in the same cycle and records the requester in a blocked mask. The next queue access that is performed releases every recorded requester through a one-cycle wake vector. The logic that stalls and restarts a requester lives outside this block.

Top module: `tagcell_top`

## Requirements
- R1: After reset the empty flag is 1 and the full flag, spare flag, entry count, blocked mask and wake vector are 0. A tag read returns 1 at bit 17 and log2(DEPTH) in bits 31:28.
- R2: View codes are 0 = raw, 1 = tag, 2 = waiting queue, 3 = polling queue. A tag read returns: empty flag at bit 0, full flag at bit 1, spare flag at bit 16, constant 1 at bit 17, entry count from bit 18 upward, depth code at bits 31:28. All other bits are 0.
- R3: A tag write loads the spare flag from data bit 16, the full flag from bit 1 and the empty flag from bit 0. When data bit 0 is 1, the entry count becomes 0.
- R4: A performed queue read clears the full flag. If the count is nonzero, it returns the oldest entry in the same cycle and removes it; otherwise it returns 0. It sets the empty flag when the count ends at 0.
- R5: A performed queue write clears the empty flag. If the count is below DEPTH, it appends the data; a write to a queue holding DEPTH entries is dropped. It sets the full flag when the count ends at DEPTH.
- R6: A waiting-queue read while the empty flag is 1, or a waiting-queue write while the full flag is 1, raises rspRetry in the same cycle and sets the requester's bit in blockedMask. Only the full flag (on a read) or the empty flag (on a write) is cleared; the count and the data are unchanged.
- R7: A performed queue access drives wakePulse, in the following cycle only, with the blocked mask as it stood before the access, and clears blockedMask.
- R8: A raw read returns the oldest entry without removing it.
- R9: A raw write overwrites the newest entry when the count is nonzero and has no effect when the count is 0.
- R10: Entries leave in arrival order, and the storage positions wrap modulo DEPTH across any number of pushes and pops.
- R11: rspData is 0 for every write and for any refused access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | A request is present this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqView | input | 2 | View code (raw, tag, waiting queue, polling queue) |
| reqId | input | $clog2(REQ_N) | Requester identity |
| reqWData | input | DATA_W | Write data or tag word |
| rspRetry | output | 1 | Access refused, requester blocked (same cycle) |
| rspData | output | DATA_W | Read data (same cycle) |
| blockedMask | output | REQ_N | One bit per blocked requester |
| wakePulse | output | REQ_N | One-cycle release vector |

## Verification
The bench builds the cell with DEPTH = 4, DATA_W = 64 and REQ_N = 8. With only four entries the full flag, the dropped fifth write and several wraps of the storage positions are reached within a few dozen accesses. Eight requester IDs let several distinct requesters pile into the blocked mask before one performed access releases them together. Tag writes are used to force flag states that the queue alone never reaches, such as an empty flag of 0 with a count of 0.

// File: rtl/tagcell_pkg.sv
package tagcell_pkg;

  typedef enum logic [1:0] {
    VIEW_RAW   = 2'd0,
    VIEW_TAG   = 2'd1,
    VIEW_QWAIT = 2'd2,
    VIEW_QPOLL = 2'd3
  } viewT;

  typedef struct packed {
    logic push;
    logic pop;
    logic patch;
    logic flush;
  } dpStrobeT;

  localparam int TAG_EMPTY_BIT = 0;
  localparam int TAG_FULL_BIT  = 1;
  localparam int TAG_SPARE_BIT = 16;
  localparam int TAG_QUEUE_BIT = 17;
  localparam int TAG_COUNT_LSB = 18;
  localparam int TAG_DCODE_LSB = 28;
  localparam int TAG_DCODE_W   = 4;

endpackage

// File: rtl/tagcell_store.sv
module tagcell_store
  import tagcell_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int DATA_W = 64,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobeT          strobe,
  input  logic [DATA_W-1:0] wData,
  output logic [DATA_W-1:0] headData,
  output logic [CNT_W-1:0]  count
);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  rdPtr;
  logic [PTR_W-1:0]  tailIdx;
  logic [PTR_W-1:0]  lastIdx;

  assign tailIdx  = rdPtr + count[PTR_W-1:0];
  assign lastIdx  = tailIdx - PTR_W'(1);
  assign headData = mem[rdPtr];

  for (genvar g = 0; g < DEPTH; g++) begin : gEntry
    logic hit;
    assign hit = (strobe.push  && (tailIdx == PTR_W'(g))) ||
                 (strobe.patch && (lastIdx == PTR_W'(g)));
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)    mem[g] <= '0;
      else if (hit) mem[g] <= wData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (strobe.pop) rdPtr <= rdPtr + PTR_W'(1);
      if (strobe.flush)     count <= '0;
      else if (strobe.push) count <= count + CNT_W'(1);
      else if (strobe.pop)  count <= count - CNT_W'(1);
    end
  end

  assert_no_overflow_R5: assert property (@(posedge clk) disable iff (!rstN)
    count <= CNT_W'(DEPTH));
  assert_push_room_R5: assert property (@(posedge clk) disable iff (!rstN)
    strobe.push |-> (count < CNT_W'(DEPTH)));
  assert_pop_data_R4: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pop |-> (count != '0));

endmodule

// File: rtl/tagcell_ctrl.sv
module tagcell_ctrl
  import tagcell_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int DATA_W = 64,
  parameter int REQ_N  = 8,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = PTR_W + 1,
  localparam int ID_W  = $clog2(REQ_N)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  viewT              reqView,
  input  logic [ID_W-1:0]   reqId,
  input  logic              tagSpareIn,
  input  logic              tagFullIn,
  input  logic              tagEmptyIn,
  input  logic [CNT_W-1:0]  count,
  input  logic [DATA_W-1:0] headData,
  output dpStrobeT          strobe,
  output logic              rspRetry,
  output logic [DATA_W-1:0] rspData,
  output logic [REQ_N-1:0]  blockedMask,
  output logic [REQ_N-1:0]  wakePulse
);

  logic emptyQ, fullQ, spareQ;
  logic emptyN, fullN, spareN;
  logic isQueue, isWait, isRaw, isTag;
  logic refuse, proceedQ;
  logic [CNT_W-1:0]  cntAfter;
  logic [DATA_W-1:0] tagWord;

  assign isQueue  = reqValid && ((reqView == VIEW_QWAIT) || (reqView == VIEW_QPOLL));
  assign isWait   = reqView == VIEW_QWAIT;
  assign isRaw    = reqValid && (reqView == VIEW_RAW);
  assign isTag    = reqValid && (reqView == VIEW_TAG);
  assign refuse   = isQueue && isWait && (reqWrite ? fullQ : emptyQ);
  assign proceedQ = isQueue && !refuse;
  assign rspRetry = refuse;

  always_comb begin
    strobe       = '0;
    strobe.pop   = proceedQ && !reqWrite && (count != '0);
    strobe.push  = proceedQ && reqWrite && (count < CNT_W'(DEPTH));
    strobe.patch = isRaw && reqWrite && (count != '0);
    strobe.flush = isTag && reqWrite && tagEmptyIn;
  end

  always_comb begin
    cntAfter = count;
    if (strobe.push)     cntAfter = count + CNT_W'(1);
    else if (strobe.pop) cntAfter = count - CNT_W'(1);
  end

  always_comb begin
    tagWord = '0;
    tagWord[TAG_EMPTY_BIT] = emptyQ;
    tagWord[TAG_FULL_BIT]  = fullQ;
    tagWord[TAG_SPARE_BIT] = spareQ;
    tagWord[TAG_QUEUE_BIT] = 1'b1;
    tagWord[TAG_COUNT_LSB +: CNT_W] = count;
    tagWord[TAG_DCODE_LSB +: TAG_DCODE_W] = TAG_DCODE_W'(PTR_W);
  end

  always_comb begin
    rspData = '0;
    if (reqValid && !reqWrite) begin
      if (isRaw)            rspData = headData;
      else if (isTag)       rspData = tagWord;
      else if (strobe.pop)  rspData = headData;
    end
  end

  always_comb begin
    emptyN = emptyQ;
    fullN  = fullQ;
    spareN = spareQ;
    if (isTag && reqWrite) begin
      spareN = tagSpareIn;
      fullN  = tagFullIn;
      emptyN = tagEmptyIn;
    end else if (isQueue && !reqWrite) begin
      fullN = 1'b0;
      if (!refuse && (cntAfter == '0)) emptyN = 1'b1;
    end else if (isQueue && reqWrite) begin
      emptyN = 1'b0;
      if (!refuse && (cntAfter == CNT_W'(DEPTH))) fullN = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      emptyQ      <= 1'b1;
      fullQ       <= 1'b0;
      spareQ      <= 1'b0;
      blockedMask <= '0;
      wakePulse   <= '0;
    end else begin
      emptyQ <= emptyN;
      fullQ  <= fullN;
      spareQ <= spareN;
      if (refuse) begin
        blockedMask <= blockedMask | (REQ_N'(1) << reqId);
        wakePulse   <= '0;
      end else if (proceedQ) begin
        blockedMask <= '0;
        wakePulse   <= blockedMask;
      end else begin
        wakePulse   <= '0;
      end
    end
  end

  assert_retry_only_wait_R6: assert property (@(posedge clk) disable iff (!rstN)
    rspRetry |-> (reqValid && (reqView == VIEW_QWAIT)));
  assert_retry_holds_count_R6: assert property (@(posedge clk) disable iff (!rstN)
    rspRetry |=> $stable(count));
  assert_retry_marks_id_R6: assert property (@(posedge clk) disable iff (!rstN)
    rspRetry |=> (blockedMask != '0));
  assert_wake_clears_mask_R7: assert property (@(posedge clk) disable iff (!rstN)
    (wakePulse != '0) |-> (blockedMask == '0));
  assert_flush_zeroes_R3: assert property (@(posedge clk) disable iff (!rstN)
    (isTag && reqWrite && tagEmptyIn) |=> (count == '0));
  assert_write_no_data_R11: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWrite) |-> (rspData == '0));

endmodule

// File: rtl/tagcell_top.sv
module tagcell_top
  import tagcell_pkg::*;
#(
  parameter int DEPTH  = 4,
  parameter int DATA_W = 64,
  parameter int REQ_N  = 8,
  localparam int ID_W  = $clog2(REQ_N),
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic              reqWrite,
  input  logic [1:0]        reqView,
  input  logic [ID_W-1:0]   reqId,
  input  logic [DATA_W-1:0] reqWData,
  output logic              rspRetry,
  output logic [DATA_W-1:0] rspData,
  output logic [REQ_N-1:0]  blockedMask,
  output logic [REQ_N-1:0]  wakePulse
);

  dpStrobeT          strobe;
  logic [DATA_W-1:0] headData;
  logic [CNT_W-1:0]  count;

  tagcell_ctrl #(.DEPTH(DEPTH), .DATA_W(DATA_W), .REQ_N(REQ_N)) u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .reqValid    (reqValid),
    .reqWrite    (reqWrite),
    .reqView     (viewT'(reqView)),
    .reqId       (reqId),
    .tagSpareIn  (reqWData[TAG_SPARE_BIT]),
    .tagFullIn   (reqWData[TAG_FULL_BIT]),
    .tagEmptyIn  (reqWData[TAG_EMPTY_BIT]),
    .count       (count),
    .headData    (headData),
    .strobe      (strobe),
    .rspRetry    (rspRetry),
    .rspData     (rspData),
    .blockedMask (blockedMask),
    .wakePulse   (wakePulse)
  );

  tagcell_store #(.DEPTH(DEPTH), .DATA_W(DATA_W)) u_store (
    .clk      (clk),
    .rstN     (rstN),
    .strobe   (strobe),
    .wData    (reqWData),
    .headData (headData),
    .count    (count)
  );

endmodule

// File: tb/tagcell_top_bench.sv
module tagcell_top_bench;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH  = 4;
  localparam int DATA_W = 64;
  localparam int REQ_N  = 8;
  localparam int ID_W   = $clog2(REQ_N);

  localparam logic [1:0] V_RAW = 2'd0, V_TAG = 2'd1, V_WAIT = 2'd2, V_POLL = 2'd3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0, reqWrite = 1'b0;
  logic [1:0] reqView = 2'd0;
  logic [ID_W-1:0] reqId = '0;
  logic [DATA_W-1:0] reqWData = '0;
  logic rspRetry;
  logic [DATA_W-1:0] rspData;
  logic [REQ_N-1:0] blockedMask, wakePulse;

  int vectors = 0;
  int misses = 0;
  bit done = 1'b0;

  // behavioural model state
  logic [DATA_W-1:0] mMem [DEPTH];
  int mHead = 0, mCnt = 0;
  bit mE = 1, mF = 0, mT = 0;
  logic [REQ_N-1:0] mMask = '0, mWake = '0;

  tagcell_top #(.DEPTH(DEPTH), .DATA_W(DATA_W), .REQ_N(REQ_N)) u_tagcell_top (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqView(reqView), .reqId(reqId), .reqWData(reqWData),
    .rspRetry(rspRetry), .rspData(rspData),
    .blockedMask(blockedMask), .wakePulse(wakePulse));

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [DATA_W-1:0] tagExp();
    logic [DATA_W-1:0] w = '0;
    w[0] = mE; w[1] = mF; w[16] = mT; w[17] = 1'b1;
    w[18 +: 8] = 8'(mCnt);
    w[28 +: 4] = 4'($clog2(DEPTH));
    return w;
  endfunction

  task automatic cmp(string req, string what, logic [DATA_W-1:0] act, logic [DATA_W-1:0] exp);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic access(string req, bit v, bit w, logic [1:0] view, int id, logic [DATA_W-1:0] d);
    logic [DATA_W-1:0] expData;
    bit expRetry;
    bit isQ;
    @(negedge clk);
    reqValid = v; reqWrite = w; reqView = view; reqId = ID_W'(id); reqWData = d;
    #1;
    isQ = v && (view == V_WAIT || view == V_POLL);
    expRetry = isQ && (view == V_WAIT) && (w ? mF : mE);
    expData = '0;
    if (v && !w && !expRetry) begin
      if (view == V_RAW) expData = mMem[mHead];
      else if (view == V_TAG) expData = tagExp();
      else if (mCnt > 0) expData = mMem[mHead];
    end
    cmp(req, "blockedMask", 64'(blockedMask), 64'(mMask));
    cmp(req, "wakePulse", 64'(wakePulse), 64'(mWake));
    cmp(req, "rspRetry", 64'(rspRetry), 64'(expRetry));
    cmp(req, "rspData", rspData, expData);
    // advance model to post-edge state
    mWake = '0;
    if (v && view == V_TAG && w) begin
      mT = d[16]; mF = d[1]; mE = d[0];
      if (d[0]) mCnt = 0;
    end else if (v && view == V_RAW && w) begin
      if (mCnt > 0) mMem[(mHead + mCnt - 1) % DEPTH] = d;
    end else if (isQ && !w) begin
      mF = 0;
      if (expRetry) mMask[id] = 1'b1;
      else begin
        mWake = mMask; mMask = '0;
        if (mCnt > 0) begin mHead = (mHead + 1) % DEPTH; mCnt--; end
        if (mCnt == 0) mE = 1;
      end
    end else if (isQ && w) begin
      mE = 0;
      if (expRetry) mMask[id] = 1'b1;
      else begin
        mWake = mMask; mMask = '0;
        if (mCnt < DEPTH) begin mMem[(mHead + mCnt) % DEPTH] = d; mCnt++; end
        if (mCnt == DEPTH) mF = 1;
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      misses++;
      vectors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) mMem[i] = '0;
    repeat (3) @(posedge clk);
    rstN = 1'b1;
    // R1 R2: reset state via tag read
    access("R1", 0, 0, V_RAW, 0, 0);
    access("R2", 1, 0, V_TAG, 0, 0);
    cmp("R1", "tag word", rspData, 64'h2002_0001);
    // R5: fill to full, fifth write dropped
    for (int i = 0; i < DEPTH; i++) access("R5", 1, 1, V_POLL, 1, 64'hA000 + i);
    access("R5", 1, 1, V_POLL, 1, 64'hDEAD);
    access("R2", 1, 0, V_TAG, 0, 0);
    // R8: raw peek twice, no pop
    access("R8", 1, 0, V_RAW, 0, 0);
    access("R8", 1, 0, V_RAW, 0, 0);
    // R9: patch newest
    access("R9", 1, 1, V_RAW, 0, 64'hBEEF);
    // R6: waiting writes on full
    access("R6", 1, 1, V_WAIT, 3, 64'h1);
    access("R6", 1, 1, V_WAIT, 5, 64'h2);
    access("R6", 1, 0, V_TAG, 0, 0);
    // R7 R4: performed read wakes 3 and 5
    access("R7", 1, 0, V_POLL, 0, 0);
    access("R7", 0, 0, V_RAW, 0, 0);
    for (int i = 0; i < DEPTH; i++) access("R4", 1, 0, V_WAIT, 0, 0);
    access("R4", 1, 0, V_POLL, 0, 0);
    // R6 on empty, R9 no effect on empty
    access("R6", 1, 0, V_WAIT, 2, 0);
    access("R9", 1, 1, V_RAW, 0, 64'h5555);
    access("R9", 1, 0, V_TAG, 0, 0);
    access("R11", 1, 1, V_WAIT, 7, 64'h77);
    access("R7", 1, 0, V_RAW, 0, 0);
    // R10: wrap several times
    for (int i = 0; i < 11; i++) begin
      access("R10", 1, 1, V_POLL, 0, 64'hC00 + i);
      access("R10", 1, 1, V_WAIT, 0, 64'hD00 + i);
      access("R10", 1, 0, V_POLL, 0, 0);
    end
    access("R10", 1, 0, V_TAG, 0, 0);
    // R3: tag write spare/flags without flush, then with flush
    access("R3", 1, 1, V_TAG, 0, 64'h0001_0000);
    access("R3", 1, 0, V_TAG, 0, 0);
    access("R3", 1, 0, V_WAIT, 4, 0);
    access("R3", 1, 1, V_TAG, 0, 64'h0000_0003);
    access("R3", 1, 0, V_TAG, 0, 0);
    access("R3", 1, 1, V_WAIT, 6, 64'h9);
    access("R3", 1, 1, V_TAG, 0, 64'h0000_0000);
    access("R4", 1, 0, V_WAIT, 0, 0);
    access("R4", 1, 0, V_TAG, 0, 0);
    access("R1", 0, 0, V_RAW, 0, 0);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

endmodule